// File: doc/BRIEF.md
# Phase-Correct PWM Timer Channel

This block is an 8-bit timer that counts from zero up to its top value of 0xFF and back down again. Each end value is held for one timer tick. One compare channel turns the counter into a symmetric, phase-correct PWM waveform. The timer steps on a tick enable. That tick comes from a free-running 10-bit prescaler of the system clock, and a 3-bit select picks the division ratio. The select can also stop the timer.

Software writes the counter and the compare register through single-cycle write strobes and can read both back. The compare register is double-buffered. The value written goes into a staging copy, and the active compare value takes that copy each time the counter reaches the top, so a change never cuts a PWM period short. A 2-bit output mode does three things:

- it connects the waveform to the pin, or leaves it disconnected;
- it picks which count direction clears the output;
- it picks which count direction sets the output.

A compare match raises a sticky interrupt flag, which is cleared by writing a 1 to it. A write to the counter suppresses the compare match on the next tick.

Top module: `pcpwm_timer`

## Requirements
- R1: After reset the counter, the readable compare value, the waveform output, the output enable and the interrupt flag are all 0. The counting direction is up.
- R2: Select 000 stops the counter. Selects 001, 010, 011, 100, 101, 110 and 111 give tick ratios of 1, 8, 32, 64, 128, 256 and 1024. A 10-bit prescaler starts at 0 when reset is released and adds 1 on every clock. A tick occurs on each clock in which the prescaler value is a multiple of the ratio.
- R3: On each tick without a counter write, the counter moves one step in the current direction. When it is at 0xFF counting up, it turns and steps to 0xFE. When it is at 0x00 counting down, it turns and steps to 0x01.
- R4: A counter write on any cycle loads the written value on the next clock. It takes priority over a tick on the same cycle and leaves the direction unchanged.
- R5: A match occurs on a tick cycle with no counter write in which the counter equals the active compare value. A match sets the flag. The flag clears on a cycle where flag_clr is 1, and a match on the same cycle wins.
- R6: After a counter write, the first tick that follows cannot produce a match. The suppression clears on that tick.
- R7: In modes 00 and 01, wave_oe and wave_o are 0, and the internal waveform state is frozen.
- R8: In mode 10, a match while counting up drives the waveform to 0, and a match while counting down drives it to 1. Mode 11 does the reverse. wave_oe is 1 in both modes.
- R9: In modes 10 and 11, an active compare value of 0xFF makes the match at the top ignored: the flag is not set. On the top tick the waveform is instead set to 1 in mode 10 and to 0 in mode 11.
- R10: cmp_o shows the last value written to the compare register at once. The active compare value loads that value only on a tick with no counter write where the counter is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Value for a counter write |
| cmp_we | input | 1 | Compare register write strobe |
| cmp_wdata | input | 8 | Value for a compare write |
| out_mode | input | 2 | Compare output mode |
| clk_sel | input | 3 | Tick ratio select, 000 stops the counter |
| flag_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| cnt_o | output | 8 | Counter value |
| cmp_o | output | 8 | Staged compare value |
| wave_o | output | 1 | PWM waveform, 0 when disconnected |
| wave_oe | output | 1 | Waveform connected to the pin |
| cmp_flag | output | 1 | Compare-match interrupt flag |

## Verification
The hardest situation to create is a counter write that sets the counter equal to the active compare value just before a tick. The compare value only becomes active after a trip through the top, so the stimulus must first wait for it to load. It then writes that exact value at ratio 1, where the write and the blocked tick are one cycle apart. A run with 0xFF staged as the compare value in both connected modes reaches the top-value special case. Long random phases then mix writes, clears and ratio changes while a bench model follows each cycle.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;
   localparam int SEL_W  = 3;
   localparam int MODE_W = 2;
   localparam int N_SEL  = 1 << SEL_W;

   typedef enum logic [MODE_W-1:0] {
      CO_OFF    = 2'b00,
      CO_RSVD   = 2'b01,
      CO_CLR_UP = 2'b10,
      CO_SET_UP = 2'b11
   } co_mode_e;

   // log2 of the tick ratio for each select code (code 0 unused)
   function automatic int ratio_log2(input int code);
      case (code)
         1:       return 0;
         2:       return 3;
         3:       return 5;
         4:       return 6;
         5:       return 7;
         6:       return 8;
         default: return 10;
      endcase
   endfunction
endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler
   import pcpwm_pkg::*;
#(
   parameter int PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   logic [PRE_W-1:0] pre_q;
   logic [N_SEL-1:0] taps;

   generate
      if (PRE_W < 10) begin : g_bad_width
         $error("pcpwm_prescaler: PRE_W must cover a ratio of 1024");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre_q <= '0;
      else        pre_q <= pre_q + PRE_W'(1);
   end

   assign taps[0] = 1'b0;
   generate
      for (genvar i = 1; i < N_SEL; i++) begin : g_tap
         localparam logic [PRE_W-1:0] MASK = PRE_W'((1 << ratio_log2(i)) - 1);
         assign taps[i] = ((pre_q & MASK) == '0);
      end
   endgenerate

   assign tick = taps[sel];
endmodule

// File: rtl/pcpwm_updown.sv
module pcpwm_updown #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         wr,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] cnt,
   output logic         up
);
   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (wr) begin
         cnt <= wr_data;
      end else if (tick) begin
         if (up && cnt == TOP) begin
            up  <= 1'b0;
            cnt <= cnt - W'(1);
         end else if (!up && cnt == '0) begin
            up  <= 1'b1;
            cnt <= cnt + W'(1);
         end else begin
            cnt <= up ? cnt + W'(1) : cnt - W'(1);
         end
      end
   end

   // R3
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr) |=> (cnt == $past(cnt) + W'(1)) || (cnt == $past(cnt) - W'(1)));
   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr) |=> $stable(cnt));
   // R4
   load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (cnt == $past(wr_data)));
endmodule

// File: rtl/pcpwm_compare.sv
module pcpwm_compare #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         cnt_wr,
   input  logic [W-1:0] cnt,
   input  logic         connected,
   input  logic         cmp_wr,
   input  logic [W-1:0] cmp_data,
   input  logic         flag_clr,
   output logic [W-1:0] cmp_buf,
   output logic         match,
   output logic         top_fix,
   output logic         flag
);
   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] cmp_act;
   logic         blk;
   logic         ev, top_ev, special;

   assign ev      = tick & ~cnt_wr;
   assign top_ev  = ev & (cnt == TOP);
   assign special = connected & (cmp_act == TOP);
   assign match   = ev & ~blk & (cnt == cmp_act) & ~special;
   assign top_fix = top_ev & special;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_buf <= '0;
         cmp_act <= '0;
         blk     <= 1'b0;
         flag    <= 1'b0;
      end else begin
         if (cmp_wr) cmp_buf <= cmp_data;
         if (top_ev) cmp_act <= cmp_buf;
         if (cnt_wr)    blk <= 1'b1;
         else if (tick) blk <= 1'b0;
         if (match)         flag <= 1'b1;
         else if (flag_clr) flag <= 1'b0;
      end
   end

   // R5
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !match) |=> !flag);
   // R6
   block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cnt_wr) && tick && !cnt_wr) |-> !match);
   // R10
   act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act != $past(cmp_act)) |-> ($past(cnt) == TOP));
endmodule

// File: rtl/pcpwm_wavegen.sv
module pcpwm_wavegen
   import pcpwm_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              up,
   input  logic              match,
   input  logic              top_fix,
   output logic              wave_o,
   output logic              wave_oe
);
   logic wave_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave_q <= 1'b0;
      end else if (mode[1]) begin
         if (top_fix)    wave_q <= ~mode[0];
         else if (match) wave_q <= up ? mode[0] : ~mode[0];
      end
   end

   assign wave_oe = mode[1];
   assign wave_o  = wave_q & wave_oe;

   // R7
   frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode[1] |=> $stable(wave_q));
endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
   import pcpwm_pkg::*;
#(
   parameter int W     = 8,
   parameter int PRE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_we,
   input  logic [W-1:0]      cnt_wdata,
   input  logic              cmp_we,
   input  logic [W-1:0]      cmp_wdata,
   input  logic [MODE_W-1:0] out_mode,
   input  logic [SEL_W-1:0]  clk_sel,
   input  logic              flag_clr,
   output logic [W-1:0]      cnt_o,
   output logic [W-1:0]      cmp_o,
   output logic              wave_o,
   output logic              wave_oe,
   output logic              cmp_flag
);
   logic tick, up, match, top_fix;

   generate
      if (W < 2) begin : g_bad_w
         $error("pcpwm_timer: W must be at least 2");
      end
   endgenerate

   pcpwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .sel(clk_sel), .tick(tick)
   );

   pcpwm_updown #(.W(W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr(cnt_we),
      .wr_data(cnt_wdata), .cnt(cnt_o), .up(up)
   );

   pcpwm_compare #(.W(W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_we),
      .cnt(cnt_o), .connected(out_mode[1]), .cmp_wr(cmp_we),
      .cmp_data(cmp_wdata), .flag_clr(flag_clr), .cmp_buf(cmp_o),
      .match(match), .top_fix(top_fix), .flag(cmp_flag)
   );

   pcpwm_wavegen u_wave (
      .clk(clk), .rst_n(rst_n), .mode(out_mode), .up(up),
      .match(match), .top_fix(top_fix), .wave_o(wave_o), .wave_oe(wave_oe)
   );

   // R2
   stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == '0 && !cnt_we) |=> $stable(cnt_o));
endmodule

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb;
   logic       clk = 0;
   logic       rst_n = 0;
   logic       cnt_we = 0, cmp_we = 0, flag_clr = 0;
   logic [7:0] cnt_wdata = 0, cmp_wdata = 0;
   logic [1:0] out_mode = 0;
   logic [2:0] clk_sel = 0;
   logic [7:0] cnt_o, cmp_o;
   logic       wave_o, wave_oe, cmp_flag;

   int total = 0, bad = 0;
   bit done = 0;
   string tag_wave = "R8", tag_flag = "R5";

   // model state
   int   m_pre;
   logic [7:0] m_cnt, m_buf, m_act;
   logic m_up, m_blk, m_flag, m_wave;

   always #4 clk = ~clk;

   pcpwm_timer u_dut (
      .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
      .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .out_mode(out_mode),
      .clk_sel(clk_sel), .flag_clr(flag_clr), .cnt_o(cnt_o), .cmp_o(cmp_o),
      .wave_o(wave_o), .wave_oe(wave_oe), .cmp_flag(cmp_flag)
   );

   function automatic int ratio(input logic [2:0] s);
      case (s)
         3'd1: return 1;    3'd2: return 8;   3'd3: return 32;
         3'd4: return 64;   3'd5: return 128; 3'd6: return 256;
         default: return 1024;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_buf = 0; m_act = 0;
         m_up = 1; m_blk = 0; m_flag = 0; m_wave = 0;
      end else begin
         bit tk, ev, top, spec, mt;
         tk   = (clk_sel != 0) && (m_pre % ratio(clk_sel) == 0);
         m_pre = (m_pre + 1) % 1024;
         ev   = tk && !cnt_we;
         top  = ev && m_cnt == 8'hFF;
         spec = out_mode[1] && m_act == 8'hFF;
         mt   = ev && !m_blk && m_cnt == m_act && !spec;
         if (mt) m_flag = 1; else if (flag_clr) m_flag = 0;
         if (out_mode[1]) begin
            if (top && spec) m_wave = ~out_mode[0];
            else if (mt)     m_wave = m_up ? out_mode[0] : ~out_mode[0];
         end
         if (cnt_we) m_blk = 1; else if (tk) m_blk = 0;
         if (top) m_act = m_buf;
         if (cmp_we) m_buf = cmp_wdata;
         if (cnt_we) m_cnt = cnt_wdata;
         else if (tk) begin
            if (m_up && m_cnt == 8'hFF)     begin m_up = 0; m_cnt = 8'hFE; end
            else if (!m_up && m_cnt == 0)   begin m_up = 1; m_cnt = 8'h01; end
            else m_cnt = m_up ? m_cnt + 8'd1 : m_cnt - 8'd1;
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // one clock, then compare all outputs to the model at the falling edge
   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
      check("R3 cnt", cnt_o, m_cnt);
      check("R10 cmp_o", cmp_o, m_buf);
      check({tag_wave, " wave"}, wave_o, m_wave & out_mode[1]);
      check("R8 oe", wave_oe, out_mode[1]);
      check({tag_flag, " flag"}, cmp_flag, m_flag);
      cnt_we = 0; cmp_we = 0; flag_clr = 0;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cyc();
   endtask

   initial begin
      #(8 * 190000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog R3 act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      check("R1 cnt", cnt_o, 0);   check("R1 cmp", cmp_o, 0);
      check("R1 wave", wave_o, 0); check("R1 oe", wave_oe, 0);
      check("R1 flag", cmp_flag, 0);
      rst_n = 1;

      // R2 stopped select: counter frozen
      clk_sel = 0; out_mode = 2'b10;
      run(40);
      check("R2 stopped", cnt_o, 0);

      // R8 mode 10 with compare 0x40 over two periods
      clk_sel = 1; cmp_we = 1; cmp_wdata = 8'h40;
      run(1100);
      // R8 mode 11 with compare 0x90
      out_mode = 2'b11; cmp_we = 1; cmp_wdata = 8'h90;
      run(1100);

      // R9 compare at top in both connected modes
      tag_wave = "R9"; tag_flag = "R9";
      cmp_we = 1; cmp_wdata = 8'hFF;
      run(1100);
      out_mode = 2'b10;
      run(1100);
      tag_wave = "R8"; tag_flag = "R5";

      // R7 disconnected modes
      out_mode = 2'b00; cmp_we = 1; cmp_wdata = 8'h20;
      run(600);
      check("R7 wave off", wave_o, 0); check("R7 oe off", wave_oe, 0);
      out_mode = 2'b01;
      run(600);
      check("R7 rsvd wave", wave_o, 0); check("R7 rsvd oe", wave_oe, 0);

      // R6 write the active compare value just before a tick
      out_mode = 2'b10;
      flag_clr = 1; cyc();
      cnt_we = 1; cnt_wdata = 8'h20; cyc();
      check("R4 load", cnt_o, 8'h20);
      cyc();
      check("R6 blocked flag", cmp_flag, 0);
      // R4 write on a tick cycle wins over the step
      cnt_we = 1; cnt_wdata = 8'h77; cyc();
      check("R4 priority", cnt_o, 8'h77);
      run(300);

      // R2 every ratio
      for (int s = 2; s < 8; s++) begin
         clk_sel = 3'(s);
         run(1500);
      end

      // constrained random mix
      for (int i = 0; i < 30000; i++) begin
         int r = $urandom_range(0, 999);
         if (r < 6)  begin cnt_we = 1; cnt_wdata = 8'($urandom); end
         if (r >= 6 && r < 12) begin cmp_we = 1; cmp_wdata = 8'($urandom); end
         if (r >= 12 && r < 22) flag_clr = 1;
         if (r == 500) out_mode = 2'($urandom);
         if (r == 501) clk_sel = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'd1;
         if (r == 502) cmp_wdata = 8'hFF;
         cyc();
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule